// File: doc/BRIEF.md
# Single-Bus Microcoded CPU Datapath

This block is the data side of a small microcoded processor. Every value moves over one shared 32-bit bus. Each clock cycle, a microinstruction picks one source for that bus and any number of destinations. The possible sources are the register file, the immediate extender, the ALU and external memory. The destinations are the instruction register, the two ALU operand latches (A and B), the memory-address register and the register file. The sequencer that issues the microinstructions sits outside this block. It drives the control points directly and branches on the status outputs: opcode, zero and busy.

The register file has 33 entries. Entries 0 to 31 are the general registers, and entry 32 is the program counter. A three-bit register-select code picks which entry is read or written. The choices are the three register fields of the instruction register, the link register (entry 31) and the program counter (entry 32), so the program counter moves over the bus like any other register. Memory is slow and external. The block presents the memory-address register as the address and the bus as the write data, and it reports the memory's busy flag back to the sequencer.

Top module: `singleBusDatapath`

## Requirements
- R1: After an asynchronous active-low reset, IR, A, B, the memory-address register and all 33 register entries hold zero, so opcode=0, zero=1, memAddr=0, and every register read gives 0.
- R2: The bus value is the OR of the gated sources: register read when enReg=1, immediate when enImm=1, ALU result when enALU=1, and memRData when enMem=1 and memWrt=0. With no source enabled the bus is 0. At most one source may be enabled per cycle.
- R3: On a rising clock edge, each of ldIR, ldA, ldB and ldMA loads the current bus value into its register. The memory-address register appears on memAddr.
- R4: regSel chooses the register entry that is read and written: 0 = IR[25:21], 1 = IR[20:16], 2 = IR[15:11], 3 = entry 31 (link), 4 = entry 32 (PC). Codes 5 to 7 select entry 0. When regWr=1, the bus value is written into the selected entry on the clock edge.
- R5: Entry 0 always reads as zero, and writes to it have no effect.
- R6: extSel shapes IR[15:0] as follows: 0 = sign-extended, 1 = zero-extended, 2 = sign-extended then shifted left by 2, 3 = IR[25:0] zero-extended.
- R7: The ALU result on opSel is: 0 = A+B, 1 = A−B, 2 = A&B, 3 = A|B, 4 = A^B, 5 = signed A<B (1 or 0), 6 = A, 7 = A+4. Codes 9 to 15 give 0.
- R8: opSel 8 gives the jump target {A[31:28], B[25:0], 2'b00}.
- R9: opcode is IR[31:26], zero is 1 exactly when A is 0, and busy follows memBusy.
- R10: memReq equals enMem. memWe is 1 only when enMem=1 and memWrt=1. memWData carries the bus value. During a write, memRData does not reach the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ldIR | input | 1 | Load instruction register from bus |
| ldA | input | 1 | Load operand latch A from bus |
| ldB | input | 1 | Load operand latch B from bus |
| ldMA | input | 1 | Load memory-address register from bus |
| regWr | input | 1 | Write bus into the selected register entry |
| regSel | input | 3 | Register entry select code |
| enReg | input | 1 | Register file drives the bus |
| extSel | input | 2 | Immediate extension mode |
| enImm | input | 1 | Immediate extender drives the bus |
| opSel | input | 4 | ALU function code |
| enALU | input | 1 | ALU drives the bus |
| enMem | input | 1 | Memory access enable |
| memWrt | input | 1 | Memory write (1) or read (0) |
| memRData | input | 32 | Read data from memory |
| memBusy | input | 1 | Memory access in progress |
| busValue | output | 32 | Current value on the shared bus |
| opcode | output | 6 | IR[31:26] |
| zero | output | 1 | A equals zero |
| busy | output | 1 | Memory busy status |
| memAddr | output | 32 | Memory-address register |
| memWData | output | 32 | Write data to memory (the bus) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write strobe |

## Verification
The hardest state to reach from the ports is the ALU with arbitrary 32-bit operands. Neither A nor B can be set directly: each value has to travel over the bus in an earlier cycle. The bench therefore acts as the memory. For each table vector it returns the A operand on one cycle with ldA set, returns the B operand on the next cycle with ldB set, and then samples the ALU result on the bus. The same route loads an instruction word into IR, which lets the bench test the register-field selects and the four immediate modes against a known encoding.

// File: rtl/sbPkg.sv
package sbPkg;
  localparam int XLEN      = 32;
  localparam int GPR_COUNT = 32;
  localparam int ENTRIES   = GPR_COUNT + 1;          // GPRs plus PC
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int IMM_W     = 16;
  localparam int JFLD_W    = 26;
  localparam int OPC_W     = 6;
  localparam int OP_W      = 4;

  // register select codes
  localparam logic [2:0] RSEL_RS   = 3'd0;
  localparam logic [2:0] RSEL_RT   = 3'd1;
  localparam logic [2:0] RSEL_RD   = 3'd2;
  localparam logic [2:0] RSEL_LINK = 3'd3;
  localparam logic [2:0] RSEL_PC   = 3'd4;

  // immediate modes
  localparam logic [1:0] EXT_SIGN  = 2'd0;
  localparam logic [1:0] EXT_ZERO  = 2'd1;
  localparam logic [1:0] EXT_BOFS  = 2'd2;
  localparam logic [1:0] EXT_JFLD  = 2'd3;

  // ALU codes
  localparam logic [OP_W-1:0] ALU_ADD  = 4'd0;
  localparam logic [OP_W-1:0] ALU_SUB  = 4'd1;
  localparam logic [OP_W-1:0] ALU_AND  = 4'd2;
  localparam logic [OP_W-1:0] ALU_OR   = 4'd3;
  localparam logic [OP_W-1:0] ALU_XOR  = 4'd4;
  localparam logic [OP_W-1:0] ALU_SLT  = 4'd5;
  localparam logic [OP_W-1:0] ALU_PASS = 4'd6;
  localparam logic [OP_W-1:0] ALU_INC4 = 4'd7;
  localparam logic [OP_W-1:0] ALU_JTGT = 4'd8;

  typedef struct packed {
    logic            ldIR;
    logic            ldA;
    logic            ldB;
    logic            ldMA;
    logic            regWr;
    logic            enReg;
    logic            enImm;
    logic            enALU;
    logic            memRead;
    logic [2:0]      regSel;
    logic [1:0]      extSel;
    logic [OP_W-1:0] opSel;
  } strobe_t;
endpackage

// File: rtl/sbStrobePack.sv
module sbStrobePack
  import sbPkg::*;
(
  input  logic            ldIR,
  input  logic            ldA,
  input  logic            ldB,
  input  logic            ldMA,
  input  logic            regWr,
  input  logic [2:0]      regSel,
  input  logic            enReg,
  input  logic [1:0]      extSel,
  input  logic            enImm,
  input  logic [OP_W-1:0] opSel,
  input  logic            enALU,
  input  logic            enMem,
  input  logic            memWrt,
  output strobe_t         stb
);
  always_comb begin
    stb.ldIR    = ldIR;
    stb.ldA     = ldA;
    stb.ldB     = ldB;
    stb.ldMA    = ldMA;
    stb.regWr   = regWr;
    stb.enReg   = enReg;
    stb.enImm   = enImm;
    stb.enALU   = enALU;
    stb.memRead = enMem & ~memWrt;
    stb.regSel  = regSel;
    stb.extSel  = extSel;
    stb.opSel   = opSel;
  end
endmodule

// File: rtl/sbRegFile.sv
module sbRegFile #(
  parameter int W       = 32,
  parameter int DEPTH   = 33,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] idx,
  input  logic             wrEn,
  input  logic [W-1:0]     wrData,
  output logic [W-1:0]     rdData
);
  logic [W-1:0] entry [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) entry[i] <= '0;
    end else if (wrEn && idx != '0 && int'(idx) < DEPTH) begin
      entry[idx] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (idx != '0 && int'(idx) < DEPTH) rdData = entry[idx];
  end
endmodule

// File: rtl/sbAlu.sv
module sbAlu
  import sbPkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [OP_W-1:0] op,
  output logic [XLEN-1:0] y
);
  localparam int SEG_W = XLEN - JFLD_W - 2;

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_SLT:  y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_PASS: y = a;
      ALU_INC4: y = a + XLEN'(4);
      ALU_JTGT: y = {a[XLEN-1 -: SEG_W], b[JFLD_W-1:0], 2'b00};
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/sbDatapath.sv
module sbDatapath
  import sbPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [XLEN-1:0]  memRData,
  output logic [XLEN-1:0]  busValue,
  output logic [XLEN-1:0]  maQ,
  output logic [OPC_W-1:0] opcode,
  output logic             aIsZero
);
  logic [XLEN-1:0]  irQ, aQ, bQ;
  logic [XLEN-1:0]  regRd, immVal, aluY;
  logic [IDX_W-1:0] regIdx;
  logic [IMM_W-1:0] immFld;

  assign immFld = irQ[IMM_W-1:0];

  // register select decode
  always_comb begin
    unique case (stb.regSel)
      RSEL_RS:   regIdx = IDX_W'(irQ[25:21]);
      RSEL_RT:   regIdx = IDX_W'(irQ[20:16]);
      RSEL_RD:   regIdx = IDX_W'(irQ[15:11]);
      RSEL_LINK: regIdx = IDX_W'(GPR_COUNT - 1);
      RSEL_PC:   regIdx = IDX_W'(GPR_COUNT);
      default:   regIdx = '0;
    endcase
  end

  // immediate extension
  always_comb begin
    unique case (stb.extSel)
      EXT_SIGN: immVal = {{(XLEN-IMM_W){immFld[IMM_W-1]}}, immFld};
      EXT_ZERO: immVal = {{(XLEN-IMM_W){1'b0}}, immFld};
      EXT_BOFS: immVal = {{(XLEN-IMM_W-2){immFld[IMM_W-1]}}, immFld, 2'b00};
      default:  immVal = {{(XLEN-JFLD_W){1'b0}}, irQ[JFLD_W-1:0]};
    endcase
  end

  sbRegFile #(.W(XLEN), .DEPTH(ENTRIES), .IDX_W(IDX_W)) uRegs (
    .clk(clk), .rstN(rstN), .idx(regIdx), .wrEn(stb.regWr),
    .wrData(busValue), .rdData(regRd)
  );

  sbAlu uAlu (.a(aQ), .b(bQ), .op(stb.opSel), .y(aluY));

  // AND-OR bus: gated sources
  assign busValue = ({XLEN{stb.enReg}}   & regRd)
                  | ({XLEN{stb.enImm}}   & immVal)
                  | ({XLEN{stb.enALU}}   & aluY)
                  | ({XLEN{stb.memRead}} & memRData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irQ <= '0;
      aQ  <= '0;
      bQ  <= '0;
      maQ <= '0;
    end else begin
      if (stb.ldIR) irQ <= busValue;
      if (stb.ldA)  aQ  <= busValue;
      if (stb.ldB)  bQ  <= busValue;
      if (stb.ldMA) maQ <= busValue;
    end
  end

  assign opcode  = irQ[XLEN-1 -: OPC_W];
  assign aIsZero = (aQ == '0);
endmodule

// File: rtl/singleBusDatapath.sv
module singleBusDatapath
  import sbPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ldIR,
  input  logic             ldA,
  input  logic             ldB,
  input  logic             ldMA,
  input  logic             regWr,
  input  logic [2:0]       regSel,
  input  logic             enReg,
  input  logic [1:0]       extSel,
  input  logic             enImm,
  input  logic [3:0]       opSel,
  input  logic             enALU,
  input  logic             enMem,
  input  logic             memWrt,
  input  logic [31:0]      memRData,
  input  logic             memBusy,
  output logic [31:0]      busValue,
  output logic [5:0]       opcode,
  output logic             zero,
  output logic             busy,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWData,
  output logic             memReq,
  output logic             memWe
);
  strobe_t stb;

  sbStrobePack uCtl (
    .ldIR(ldIR), .ldA(ldA), .ldB(ldB), .ldMA(ldMA), .regWr(regWr),
    .regSel(regSel), .enReg(enReg), .extSel(extSel), .enImm(enImm),
    .opSel(opSel), .enALU(enALU), .enMem(enMem), .memWrt(memWrt), .stb(stb)
  );

  sbDatapath uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .memRData(memRData),
    .busValue(busValue), .maQ(memAddr), .opcode(opcode), .aIsZero(zero)
  );

  assign busy     = memBusy;
  assign memWData = busValue;
  assign memReq   = enMem;
  assign memWe    = enMem & memWrt;
endmodule

// File: rtl/singleBusDatapathChk.sv
module singleBusDatapathChk (
  input logic        clk,
  input logic        rstN,
  input logic        ldIR,
  input logic        ldA,
  input logic        ldMA,
  input logic        enReg,
  input logic        enImm,
  input logic        enALU,
  input logic        enMem,
  input logic        memWrt,
  input logic [31:0] memRData,
  input logic [31:0] busValue,
  input logic [5:0]  opcode,
  input logic        zero,
  input logic [31:0] memAddr
);
  // R2
  one_driver_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({enReg, enImm, enALU, enMem & ~memWrt}));

  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(enReg || enImm || enALU || enMem) |-> busValue == 32'h0);

  // R3
  ma_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldMA |=> memAddr == $past(busValue));

  // R9
  opcode_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldIR |=> opcode == $past(busValue[31:26]));

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldA |=> zero == ($past(busValue) == 32'h0));

  // R10
  mem_read_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enMem && !memWrt && !enReg && !enImm && !enALU) |-> busValue == memRData);
endmodule

bind singleBusDatapath singleBusDatapathChk uChk (.*);

// File: tb/tb_singleBusDatapath.sv
module tb_singleBusDatapath;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ldIR = 0, ldA = 0, ldB = 0, ldMA = 0, regWr = 0;
  logic [2:0]  regSel = 0;
  logic        enReg = 0, enImm = 0, enALU = 0, enMem = 0, memWrt = 0;
  logic [1:0]  extSel = 0;
  logic [3:0]  opSel = 0;
  logic [31:0] memRData = 0;
  logic        memBusy = 0;
  logic [31:0] busValue, memAddr, memWData;
  logic [5:0]  opcode;
  logic        zero, busy, memReq, memWe;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  singleBusDatapath dut (.*);

  // {opSel, A, B, expected}
  localparam logic [99:0] VECS [14] = '{
    {4'd0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
    {4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
    {4'd1, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE},
    {4'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000},
    {4'd3, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hFFF0_FFF0},
    {4'd4, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0},
    {4'd5, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
    {4'd5, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'd5, 32'h0000_0007, 32'h0000_0007, 32'h0000_0000},
    {4'd6, 32'h1234_5678, 32'hAAAA_AAAA, 32'h1234_5678},
    {4'd7, 32'hFFFF_FFFC, 32'h0000_0000, 32'h0000_0000},
    {4'd8, 32'hA000_0000, 32'h03FF_FFFF, 32'hAFFF_FFFC},
    {4'd8, 32'h5FFF_FFFF, 32'hFC00_0001, 32'h5000_0004},
    {4'd9, 32'h1234_5678, 32'h1111_1111, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ldIR = 0; ldA = 0; ldB = 0; ldMA = 0; regWr = 0;
    enReg = 0; enImm = 0; enALU = 0; enMem = 0; memWrt = 0;
  endtask

  // apply current inputs across one rising edge, return 2ns after it
  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic memToBus(input logic [31:0] v);
    idle(); enMem = 1; memRData = v;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] irWord;
    irWord = 32'h8CA0_8004;   // opcode 0x23, rs=5, rt=0, rd=16, imm=0x8004

    repeat (3) @(posedge clk);
    #2 rstN = 1;
    tick();

    // R1 reset state
    check("R1 opcode", {26'h0, opcode}, 32'h0);
    check("R1 zero", {31'h0, zero}, 32'h1);
    check("R1 memAddr", memAddr, 32'h0);
    idle(); enReg = 1; regSel = 3'd4; #1;
    check("R1 pc entry", busValue, 32'h0);
    regSel = 3'd3; #1;
    check("R1 link entry", busValue, 32'h0);

    // R2 idle bus reads zero despite memory data
    idle(); memRData = 32'hFFFF_FFFF; #1;
    check("R2 idle bus", busValue, 32'h0);

    // R7/R8 ALU vector table
    for (int i = 0; i < 14; i++) begin
      memToBus(VECS[i][95:64]); ldA = 1; tick();
      memToBus(VECS[i][63:32]); ldB = 1; tick();
      idle(); enALU = 1; opSel = VECS[i][99:96]; #1;
      check(VECS[i][99:96] == 4'd8 ? "R8 jump target" : "R7 alu", busValue, VECS[i][31:0]);
    end

    // R9 zero flag
    memToBus(32'h0); ldA = 1; tick();
    check("R9 zero set", {31'h0, zero}, 32'h1);
    memToBus(32'h0000_0100); ldA = 1; tick();
    check("R9 zero clear", {31'h0, zero}, 32'h0);

    // R3 / R9 instruction register load
    memToBus(irWord); ldIR = 1; tick();
    check("R9 opcode", {26'h0, opcode}, 32'h23);

    // R6 immediate modes
    idle(); enImm = 1; extSel = 2'd0; #1;
    check("R6 sign ext", busValue, 32'hFFFF_8004);
    extSel = 2'd1; #1;
    check("R6 zero ext", busValue, 32'h0000_8004);
    extSel = 2'd2; #1;
    check("R6 branch offset", busValue, 32'hFFFE_0010);
    extSel = 2'd3; #1;
    check("R6 jump field", busValue, 32'h00A0_8004);

    // R4 write and read selected entries
    memToBus(32'h1111_0005); regWr = 1; regSel = 3'd0; tick();   // rs -> entry 5
    memToBus(32'h2222_0016); regWr = 1; regSel = 3'd2; tick();   // rd -> entry 16
    memToBus(32'h3333_001F); regWr = 1; regSel = 3'd3; tick();   // link
    memToBus(32'h4444_0020); regWr = 1; regSel = 3'd4; tick();   // PC
    idle(); enReg = 1; regSel = 3'd0; #1;
    check("R4 rs entry", busValue, 32'h1111_0005);
    regSel = 3'd2; #1;
    check("R4 rd entry", busValue, 32'h2222_0016);
    regSel = 3'd3; #1;
    check("R4 link entry", busValue, 32'h3333_001F);
    regSel = 3'd4; #1;
    check("R4 pc entry", busValue, 32'h4444_0020);
    regSel = 3'd6; #1;
    check("R4 unused code", busValue, 32'h0);

    // R5 entry 0 (rt field = 0) ignores writes
    memToBus(32'hDEAD_BEEF); regWr = 1; regSel = 3'd1; tick();
    idle(); enReg = 1; regSel = 3'd1; #1;
    check("R5 r0 reads zero", busValue, 32'h0);
    memToBus(32'h5555_5555); regWr = 1; regSel = 3'd7; tick();
    idle(); enReg = 1; regSel = 3'd0; #1;
    check("R5 other entries intact", busValue, 32'h1111_0005);

    // R3 memory-address register; PC increment path A+4
    idle(); enReg = 1; regSel = 3'd4; ldA = 1; ldMA = 1; tick();
    check("R3 memAddr", memAddr, 32'h4444_0020);
    idle(); enALU = 1; opSel = 4'd7; #1;
    check("R7 pc plus 4", busValue, 32'h4444_0024);

    // R10 memory write: register drives, memory data kept off bus
    idle(); enReg = 1; regSel = 3'd3; enMem = 1; memWrt = 1; memRData = 32'hFFFF_0000; #1;
    check("R10 memWe", {31'h0, memWe}, 32'h1);
    check("R10 memReq", {31'h0, memReq}, 32'h1);
    check("R10 write data", memWData, 32'h3333_001F);
    idle(); enMem = 1; memRData = 32'h0BAD_F00D; #1;
    check("R10 read no we", {31'h0, memWe}, 32'h0);
    check("R10 read onto bus", busValue, 32'h0BAD_F00D);

    // R9 busy passthrough
    idle(); memBusy = 1; #1;
    check("R9 busy high", {31'h0, busy}, 32'h1);
    memBusy = 0; #1;
    check("R9 busy low", {31'h0, busy}, 32'h0);

    tick();
    summary();
  end
endmodule